// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master on the MAC side of a PHY management bus. A host pulses a start request together with a read/write select, a 3-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then runs exactly one management frame. It divides the system clock down to the management clock `mdc_o` and drives the bidirectional data line through a value/enable pair (`mdio_out`, `mdio_oe`). The pad's received value comes back on `mdio_in`.

A frame opens with 32 synchronising ones, then the start code, the operation code, the PHY address and the register address, all sent most significant bit first. Two turnaround bit times follow, then the 16 data bits. On a write the master drives the whole frame, and the turnaround is the pair 1,0. On a read the master lets go of the line from the first turnaround bit until the frame ends. The PHY drives 0 in the second turnaround bit and then supplies the data, which the master samples on MDC rising edges.

While idle the line is released, so the external pull-up holds it high, and MDC rests low. `busy_o` covers the whole frame. `done_o` is a single-clock pulse at the end. Read data is held on `rdata_o` until another read completes.

Top module: `mdio_master`

## Requirements
- R1: `mdc_o` has a period of 2*CLK_HALF_DIV system clocks while a frame runs. It is low for the first CLK_HALF_DIV clocks of each bit time and high for the second CLK_HALF_DIV clocks. The first low phase starts in the clock after the start request is accepted.
- R2: Bit times 0..31 carry 1. Bits 32..33 carry the start code 0,1. Bits 34..35 carry the operation code: 1,0 for read and 0,1 for write. Bits 36..38 carry the PHY address and bits 39..43 carry the register address, each MSB first.
- R3: On a write, `mdio_oe` stays high from the first drive point to the end of the frame. Bits 44..45 carry the turnaround 1,0 and bits 46..61 carry the write data MSB first.
- R4: On a read, `mdio_oe` goes low at the drive point of bit 44 and stays low to the end of the frame. The 16 values of `mdio_in` taken at the MDC rising edges of bits 46..61 form the read word, MSB first.
- R5: `mdio_out` and `mdio_oe` change only in the clock in which the MDC low-phase position reaches DRIVE_DLY+1. This is a fixed delay after the falling edge. The one exception is the release of `mdio_oe` at frame end.
- R6: While no frame runs, `mdio_oe` is 0 and `mdc_o` is 0.
- R7: `busy_o` is high from the clock after an accepted start through 62 bit times. `done_o` is high for exactly one clock, in which `busy_o` is already low.
- R8: A start request seen while `busy_o` is high has no effect, including in the last clock of a frame.
- R9: A start request in the clock where `done_o` is high is accepted, and the next frame begins at once.
- R10: `rdata_o` is 0 after reset. It changes only when a read completes and is unchanged by writes.
- R11: During reset, `busy_o`, `done_o`, `mdc_o` and `mdio_oe` are 0.
- R12: With the default divide ratio and a 250 MHz system clock, the MDC frequency is below 2.5 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one frame (taken only while idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | PHY_AW | Target PHY address |
| reg_addr_i | input | REG_AW | Target register address |
| wdata_i | input | DATA_W | Data word for a write |
| rdata_o | output | DATA_W | Last completed read word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Value seen on the data line |

## Verification
Two functions can fall in the same clock: the completion of one frame (`done_o`) and the acceptance of the next start request. The bench raises `start_i` exactly in the `done_o` clock and expects a new frame with the new fields to begin in the next clock. It also pulses `start_i` in the final busy clock and expects that pulse to be ignored. A behavioural model counts clocks since acceptance and predicts MDC, enable, data bit, busy, done and the read word in every clock. Any disagreement in either case shows up as a failed comparison.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
  localparam logic [1:0] TA_READ  = 2'b11;

  // header length in bit times: sync ones + start + op + addresses
  function automatic int hdr_bits(input int pre, input int phy_w, input int reg_w);
    return pre + 4 + phy_w + reg_w;
  endfunction

  // full frame length in bit times
  function automatic int frame_bits(input int pre, input int phy_w, input int reg_w,
                                    input int dw);
    return hdr_bits(pre, phy_w, reg_w) + 2 + dw;
  endfunction

  function automatic mdio_op_e op_code(input logic is_read);
    return is_read ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV  = 52,
  parameter int DRIVE_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic drive_tick,
  output logic sample_tick,
  output logic period_end
);
  localparam int CW = $clog2(2 * HALF_DIV);
  localparam logic [CW-1:0] LAST   = CW'(2 * HALF_DIV - 1);
  localparam logic [CW-1:0] RISE_M = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] SAMP   = CW'(HALF_DIV);
  localparam logic [CW-1:0] DRV    = CW'(DRIVE_DLY);

  logic [CW-1:0] phase_q;
  logic          mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mdc_q   <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      mdc_q   <= 1'b0;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (phase_q == RISE_M)    mdc_q <= 1'b1;
      else if (phase_q == LAST) mdc_q <= 1'b0;
    end
  end

  assign mdc         = mdc_q;
  assign drive_tick  = run && (phase_q == DRV);
  assign sample_tick = run && (phase_q == SAMP);
  assign period_end  = run && (phase_q == LAST);

  // R1: the sample point lies in the high half of the bit time
  a_r1_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> mdc_q);
  // R1: the drive point lies in the low half
  a_r1_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_tick |-> !mdc_q);
  // R6: the clock rests low when no frame runs
  a_r6_mdc_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mdio_bit_seq.sv
module mdio_bit_seq #(
  parameter int FRAME_LEN = 62,
  parameter int TA_POS    = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic period_end,
  output logic in_turn,
  output logic in_data,
  output logic frame_end
);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_LEN - 1);
  localparam logic [BW-1:0] TA_AT    = BW'(TA_POS);
  localparam logic [BW-1:0] DATA_AT  = BW'(TA_POS + 2);

  logic [BW-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bit_q <= '0;
    else if (!run)       bit_q <= '0;
    else if (period_end) bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
  end

  assign in_turn   = bit_q >= TA_AT;
  assign in_data   = bit_q >= DATA_AT;
  assign frame_end = period_end && (bit_q == LAST_BIT);

  // R2: the bit index never leaves the frame
  a_r2_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_q <= LAST_BIT));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_HALF_DIV = 52,
  parameter int DRIVE_DLY    = 2,
  parameter int PRE_LEN      = 32,
  parameter int PHY_AW       = 3,
  parameter int REG_AW       = 5,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int TA_POS    = hdr_bits(PRE_LEN, PHY_AW, REG_AW);
  localparam int FRAME_LEN = frame_bits(PRE_LEN, PHY_AW, REG_AW, DATA_W);

  logic                 busy_q, rd_q, done_q, out_q, oe_q;
  logic [FRAME_LEN-1:0] shreg_q;
  logic [DATA_W-1:0]    rcap_q, rdata_q;

  // named internal events
  logic accept, drive_tick, sample_tick, period_end;
  logic in_turn, in_data, frame_end, capture_bit;

  assign accept      = start_i && !busy_q;
  assign capture_bit = sample_tick && in_data && rd_q;

  mdio_clkgen #(.HALF_DIV(CLK_HALF_DIV), .DRIVE_DLY(DRIVE_DLY)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .mdc(mdc_o),
    .drive_tick(drive_tick), .sample_tick(sample_tick), .period_end(period_end)
  );

  mdio_bit_seq #(.FRAME_LEN(FRAME_LEN), .TA_POS(TA_POS)) seq_i (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .period_end(period_end),
    .in_turn(in_turn), .in_data(in_data), .frame_end(frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
      shreg_q <= '0;
      rcap_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        rd_q    <= rd_i;
        shreg_q <= {{PRE_LEN{1'b1}}, SOF_CODE, op_code(rd_i), phy_addr_i, reg_addr_i,
                    (rd_i ? TA_READ : TA_WRITE), wdata_i};
      end
      if (drive_tick) begin
        out_q   <= shreg_q[FRAME_LEN-1];
        oe_q    <= !(rd_q && in_turn);
        shreg_q <= shreg_q << 1;
      end
      if (capture_bit) rcap_q <= {rcap_q[DATA_W-2:0], mdio_in};
      if (frame_end) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        oe_q   <= 1'b0;
        if (rd_q) rdata_q <= rcap_q;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
  assign rdata_o  = rdata_q;

  // R6: line released when idle
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);
  // R4: read hands the line over from the turnaround on
  a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    drive_tick && rd_q && in_turn |=> !mdio_oe);
  // R3: write keeps ownership at every drive point
  a_r3_write_owns: assert property (@(posedge clk) disable iff (!rst_n)
    drive_tick && !rd_q |=> mdio_oe);
  // R5: data value only moves at a drive point
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_tick |=> $stable(mdio_out));
  // R5: enable only moves at a drive point or frame end
  a_r5_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_tick && !frame_end |=> $stable(mdio_oe));
  // R7: done is a single clock and follows busy dropping
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);
  // R8: requests during a frame leave the operation unchanged
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i && !frame_end |=> busy_q && $stable(rd_q));
  // R10: read word moves only at read completion
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && rd_q) |=> $stable(rdata_o));

endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int H     = 52;
  localparam int DRV   = 2;
  localparam int NBITS = 62;
  localparam int TOT   = NBITS * 2 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0;
  logic [2:0] phy_addr_i = '0;
  logic [4:0] reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic busy_o, done_o, mdc_o, mdio_out, mdio_oe, mdio_in;

  always #2 clk = ~clk;  // 250 MHz

  // reference model state
  int t = 0;
  bit m_active = 0, m_done = 0, m_rd = 0, was_active = 0;
  logic [2:0] m_phy = '0;
  logic [4:0] m_reg = '0;
  logic [15:0] m_wd = '0, m_rdata_exp = '0, phy_word = '0;
  int tests = 0, fails = 0;
  bit finished = 0;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o), .mdc_o(mdc_o),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  function automatic bit exp_bit(input int b);
    int k = b;
    if (k < 32) return 1'b1;
    k -= 32; if (k < 2) return (k == 1);
    k -= 2;  if (k < 2) return m_rd ? (k == 0) : (k == 1);
    k -= 2;  if (k < 3) return m_phy[2-k];
    k -= 3;  if (k < 5) return m_reg[4-k];
    k -= 5;  if (k < 2) return m_rd ? (k == 0) : (k == 0);
    k -= 2;  return m_rd ? phy_word[15-k] : m_wd[15-k];
  endfunction

  // PHY model: drives the second turnaround bit and the data on reads
  logic phy_en, phy_val;
  assign phy_en  = m_active && m_rd && (t / (2 * H)) >= 45;
  assign phy_val = (t / (2 * H)) == 45 ? 1'b0 : phy_word[15 - ((t / (2 * H)) - 46)];
  assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_val : 1'b1);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0; t = 0; m_rdata_exp = '0;
    end else begin
      was_active = m_active;
      m_done = 0;
      if (m_active) begin
        t++;
        if (t == TOT) begin
          m_active = 0; m_done = 1;
          if (m_rd) m_rdata_exp = phy_word;
        end
      end
      if (start_i && !was_active) begin
        m_active = 1; t = 0; m_rd = rd_i;
        m_phy = phy_addr_i; m_reg = reg_addr_i; m_wd = wdata_i;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ph, b, eff;
      bit e_mdc, e_oe;
      ph = t % (2 * H);
      b = t / (2 * H);
      eff = (ph > DRV) ? b : b - 1;
      e_mdc = m_active && ph >= H;
      e_oe = m_active && eff >= 0 && !(m_rd && eff >= 44);
      check(busy_o == m_active, "R7", "busy", busy_o, m_active);
      check(done_o == m_done, "R7", "done", done_o, m_done);
      check(mdc_o == e_mdc, "R1", "mdc", mdc_o, e_mdc);
      check(mdio_oe == e_oe, m_rd ? "R4" : "R3", "oe", mdio_oe, e_oe);
      if (e_oe) check(mdio_out == exp_bit(eff), eff < 44 ? "R2" : "R3", "bit",
                      mdio_out, exp_bit(eff));
      if (!m_active) check(!mdio_oe && !mdc_o, "R6", "idle", {mdio_oe, mdc_o}, 0);
      check(!(mdio_oe && phy_en), "R4", "contention", mdio_oe, 0);
      check(rdata_o == m_rdata_exp, "R10", "rdata", rdata_o, m_rdata_exp);
    end
  end

  task automatic start_frame(input bit rd, input logic [2:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] pw);
    while (m_active) @(negedge clk);
    phy_word = pw;
    rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!m_done) @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R12: divide ratio versus limit
    check((250.0e6 / (2.0 * H)) < 2.5e6, "R12", "mdc_hz", int'(250.0e6 / (2.0 * H)), 2500000);
    // R11: reset state
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mdc_o && !mdio_oe, "R11", "reset",
          {busy_o, done_o, mdc_o, mdio_oe}, 0);
    check(rdata_o == 16'h0, "R10", "rdata_reset", rdata_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    start_frame(1'b0, 3'd5, 5'h1B, 16'hA5C3, 16'h0000);   // R3 write
    wait_done();
    start_frame(1'b1, 3'd2, 5'h07, 16'h0000, 16'h3C96);   // R4 read
    // R8: request with other fields mid-frame
    repeat (1000) @(negedge clk);
    rd_i = 1'b0; phy_addr_i = 3'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    check(rdata_o == 16'h3C96, "R4", "read_word", rdata_o, 16'h3C96);
    start_frame(1'b1, 3'd7, 5'h1F, 16'h0000, 16'h0001);   // R2 extreme fields
    // R8: request in the last busy clock only
    while (!(m_active && t == TOT - 1)) @(negedge clk);
    start_i = 1'b1; rd_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    check(!busy_o && done_o, "R8", "last_clock_ignored", busy_o, 0);
    repeat (3) @(negedge clk);
    check(!busy_o, "R8", "no_new_frame", busy_o, 0);
    // R10: write must not touch rdata
    start_frame(1'b0, 3'd0, 5'h00, 16'hFFFF, 16'hBEEF);
    wait_done();
    check(rdata_o == 16'h0001, "R10", "write_keeps_rdata", rdata_o, 16'h0001);
    // R9: start in the done clock
    phy_word = 16'h8001;
    rd_i = 1'b1; phy_addr_i = 3'd3; reg_addr_i = 5'h10; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o, "R9", "back_to_back", busy_o, 1);
    wait_done();
    check(rdata_o == 16'h8001, "R9", "b2b_read_word", rdata_o, 16'h8001);
    repeat (10) @(negedge clk);
    report();
  end

endmodule